// File: doc/BRIEF.md
# Pipelined Reciprocal Unit

This block produces an approximate reciprocal of an unsigned fixed-point operand and accepts a new operand on every clock. It first shifts the operand left until its top bit is one and reports how many positions it moved. The normalized value is a mantissa in [1, 2). A small table gives a starting estimate of its inverse, and one Newton-Raphson step, x1 = x0·(2 − m·x0), refines that estimate. The unit returns the refined mantissa together with the shift count. Downstream arithmetic shifters use both to restore the true scale: 1/x = (outRecip / 2^(OUT_W−1)) · 2^(outShift − (IN_W−1)).

The table is addressed by the IDX_W bits that follow the leading one. Each entry holds the rounded inverse of the midpoint of its interval. Every multiply and subtract keeps full width, so the only loss after the seed is the final rounding. A valid strobe travels with the data through the pipeline. Each register stage loads only when the strobe says it holds a live operand. A zero operand cannot be inverted, so it raises a flag and forces the mantissa to its largest code.

Top module: `recip_unit`

## Requirements
- R1: For a nonzero operand, outShift equals the number of zero bits above the highest set bit of inX, so inX shifted left by outShift has bit IN_W−1 set. For example, 0x0001 gives 15 and 0x8000 gives 0 with the default widths.
- R2: For a nonzero operand, outRecip is an unsigned value with OUT_W−1 fraction bits. It lies within one LSB of round(2^(OUT_W+IN_W−2) / (inX << outShift)).
- R3: For a nonzero operand, outRecip lies in the range [2^(OUT_W−2), 2^(OUT_W−1)]. An operand that is a power of two gives exactly 2^(OUT_W−1).
- R4: A zero operand gives outDivZero = 1, outRecip all ones and outShift = 0. Every nonzero operand gives outDivZero = 0.
- R5: outValid goes high exactly three clock edges after the edge that captured inValid high. Operands presented on consecutive cycles give results on consecutive cycles, in the same order.
- R6: While no new result is being delivered, outValid is 0, and outRecip, outShift and outDivZero keep the values of the last result.
- R7: While rstN is low (asynchronous, active low), outValid, outRecip, outShift and outDivZero are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand on inX is to be processed this cycle |
| inX | input | IN_W | Unsigned operand |
| outValid | output | 1 | A result is presented this cycle |
| outRecip | output | OUT_W | Reciprocal mantissa of the normalized operand, OUT_W−1 fraction bits |
| outShift | output | $clog2(IN_W) | Left shift that was applied to normalize the operand |
| outDivZero | output | 1 | Operand was zero; mantissa is saturated |

## Verification
The bench builds the unit with its defaults: a 16-bit operand, a 16-bit mantissa, an 8-bit table index and a 12-bit seed. With these widths every shift count from 0 to 15 occurs. A sweep over single set bits drives each count once, and these power-of-two operands must give the exact result. Random operands hit all 256 seed intervals, including the last one, where the mantissa approaches the lower end of its range. Random gaps in inValid exercise back-to-back delivery and the holding of outputs between results.

// File: rtl/recip_pkg.sv
package recip_pkg;

  // Number of register stages between an accepted operand and its result.
  localparam int RECIP_LATENCY = 3;

  // Load strobes issued by the control to the datapath stage registers.
  typedef struct packed {
    logic ldNorm;   // capture normalized mantissa, seed, shift, zero flag
    logic ldResid;  // capture residual 2 - m*x0
    logic ldOut;    // capture refined, rounded result
  } recipStrobe_t;

endpackage

// File: rtl/recip_ctrl.sv
module recip_ctrl
  import recip_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output recipStrobe_t strobe,
  output logic         outValid
);

  logic [RECIP_LATENCY-1:0] liveQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveQ <= '0;
    end else begin
      liveQ <= {liveQ[RECIP_LATENCY-2:0], inValid};
    end
  end

  always_comb begin
    strobe.ldNorm  = inValid;
    strobe.ldResid = liveQ[0];
    strobe.ldOut   = liveQ[1];
  end

  assign outValid = liveQ[RECIP_LATENCY-1];

  // R5: an accepted operand yields a result three edges later
  assert_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##3 outValid);

  // R5: the output stage is loaded only on the cycle before a result appears
  assert_out_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldOut |=> outValid);

endmodule

// File: rtl/recip_norm.sv
module recip_norm #(
  parameter int IN_W = 16
) (
  input  logic [IN_W-1:0]         opX,
  output logic [IN_W-1:0]         normX,
  output logic [$clog2(IN_W)-1:0] shiftAmt,
  output logic                    isZero
);

  localparam int SHIFT_W = $clog2(IN_W);

  always_comb begin
    shiftAmt = '0;
    for (int i = 0; i < IN_W; i++) begin
      if (opX[i]) shiftAmt = SHIFT_W'(IN_W - 1 - i);
    end
    isZero = (opX == '0);
    normX  = opX << shiftAmt;
  end

endmodule

// File: rtl/recip_seed_rom.sv
module recip_seed_rom #(
  parameter int IDX_W  = 8,
  parameter int SEED_W = 12
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [SEED_W-1:0] seed
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int SEED_F  = SEED_W - 1;

  // Rounded inverse of the interval midpoint 1 + (k + 0.5) / 2^IDX_W.
  function automatic logic [SEED_W-1:0] midInverse(input int k);
    longint num;
    longint den;
    num = longint'(1) << (SEED_F + IDX_W + 2);
    den = (longint'(1) << (IDX_W + 1)) + longint'(2 * k + 1);
    return SEED_W'(((num / den) + 1) >> 1);
  endfunction

  logic [SEED_W-1:0] seedTab [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    localparam logic [SEED_W-1:0] ENTRY_VAL = midInverse(g);
    assign seedTab[g] = ENTRY_VAL;
  end

  assign seed = seedTab[idx];

endmodule

// File: rtl/recip_datapath.sv
module recip_datapath
  import recip_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int OUT_W  = 16,
  parameter int IDX_W  = 8,
  parameter int SEED_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  recipStrobe_t            strobe,
  input  logic [IN_W-1:0]         inX,
  output logic [OUT_W-1:0]        outRecip,
  output logic [$clog2(IN_W)-1:0] outShift,
  output logic                    outDivZero
);

  localparam int SHIFT_W = $clog2(IN_W);
  localparam int MANT_F  = IN_W - 1;           // fraction bits of mantissa
  localparam int SEED_F  = SEED_W - 1;         // fraction bits of seed
  localparam int PROD_W  = IN_W + SEED_W;      // m*x0 and residual width
  localparam int PROD_F  = MANT_F + SEED_F;
  localparam int REF_W   = PROD_W + SEED_W;    // refined product width
  localparam int REF_F   = PROD_F + SEED_F;
  localparam int DROP    = REF_F - (OUT_W - 1);
  localparam logic [PROD_W-1:0] TWO_P    = PROD_W'(1) << (PROD_F + 1);
  localparam logic [PROD_W-1:0] ONE_P    = PROD_W'(1) << PROD_F;
  localparam logic [PROD_W-1:0] BAND_P   = PROD_W'(1) << (PROD_F - 7);
  localparam logic [REF_W-1:0]  RND_HALF = REF_W'(1) << (DROP - 1);
  localparam logic [REF_W-1:0]  OUT_MAX  = REF_W'({OUT_W{1'b1}});
  localparam logic [SEED_W-1:0] SEED_ONE = SEED_W'(1) << SEED_F;
  localparam logic [SEED_W-1:0] SEED_HLF = SEED_W'(1) << (SEED_F - 1);

  // ---------------- stage 1: normalize and look up seed ----------------
  logic [IN_W-1:0]    nrmX;
  logic [SHIFT_W-1:0] nrmShift;
  logic               nrmZero;
  logic [SEED_W-1:0]  seedRaw;

  recip_norm #(.IN_W(IN_W)) u_norm (
    .opX      (inX),
    .normX    (nrmX),
    .shiftAmt (nrmShift),
    .isZero   (nrmZero)
  );

  recip_seed_rom #(.IDX_W(IDX_W), .SEED_W(SEED_W)) u_seed (
    .idx  (nrmX[IN_W-2 -: IDX_W]),
    .seed (seedRaw)
  );

  logic [IN_W-1:0]    mant1Q;
  logic [SEED_W-1:0]  seed1Q;
  logic [SHIFT_W-1:0] shift1Q;
  logic               zero1Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mant1Q  <= '0;
      seed1Q  <= '0;
      shift1Q <= '0;
      zero1Q  <= 1'b0;
    end else if (strobe.ldNorm) begin
      mant1Q  <= nrmX;
      seed1Q  <= seedRaw;
      shift1Q <= nrmZero ? '0 : nrmShift;
      zero1Q  <= nrmZero;
    end
  end

  // ---------------- stage 2: residual 2 - m*x0 ----------------
  logic [PROD_W-1:0] prodMx;
  logic [PROD_W-1:0] resid;

  always_comb begin
    prodMx = PROD_W'(mant1Q) * PROD_W'(seed1Q);
    resid  = TWO_P - prodMx;
  end

  logic [PROD_W-1:0]  resid2Q;
  logic [SEED_W-1:0]  seed2Q;
  logic [SHIFT_W-1:0] shift2Q;
  logic               zero2Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resid2Q <= '0;
      seed2Q  <= '0;
      shift2Q <= '0;
      zero2Q  <= 1'b0;
    end else if (strobe.ldResid) begin
      resid2Q <= resid;
      seed2Q  <= seed1Q;
      shift2Q <= shift1Q;
      zero2Q  <= zero1Q;
    end
  end

  // ---------------- stage 3: x1 = x0 * residual, round ----------------
  logic [REF_W-1:0] refined;
  logic [REF_W-1:0] rounded;
  logic [OUT_W-1:0] mantOut;

  always_comb begin
    refined = REF_W'(seed2Q) * REF_W'(resid2Q);
    rounded = (refined + RND_HALF) >> DROP;
    if (zero2Q || (rounded > OUT_MAX)) begin
      mantOut = '1;
    end else begin
      mantOut = rounded[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outRecip   <= '0;
      outShift   <= '0;
      outDivZero <= 1'b0;
    end else if (strobe.ldOut) begin
      outRecip   <= mantOut;
      outShift   <= shift2Q;
      outDivZero <= zero2Q;
    end
  end

  // R1: the normalizer leaves the leading one in the top bit
  assert_norm_msb_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldNorm && !nrmZero) |-> nrmX[IN_W-1]);

  // R2: a table seed is the inverse of a value in [1,2)
  assert_seed_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldNorm && !nrmZero) |-> (seedRaw > SEED_HLF && seedRaw <= SEED_ONE));

  // R2: the seed error is small, so the residual stays close to one
  assert_resid_band_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldResid && !zero1Q) |-> (resid >= ONE_P - BAND_P && resid <= ONE_P + BAND_P));

  // R4: a zero operand leaves the stage saturated with a cleared shift
  assert_zero_sat_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldOut && zero2Q) |=> (outDivZero && outRecip == '1 && outShift == '0));

endmodule

// File: rtl/recip_unit.sv
module recip_unit
  import recip_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int OUT_W  = 16,
  parameter int IDX_W  = 8,
  parameter int SEED_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [IN_W-1:0]         inX,
  output logic                    outValid,
  output logic [OUT_W-1:0]        outRecip,
  output logic [$clog2(IN_W)-1:0] outShift,
  output logic                    outDivZero
);

  localparam logic [OUT_W-1:0] MANT_LO = OUT_W'(1) << (OUT_W - 2);
  localparam logic [OUT_W-1:0] MANT_HI = OUT_W'(1) << (OUT_W - 1);

  recipStrobe_t strobe;

  recip_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  recip_datapath #(
    .IN_W   (IN_W),
    .OUT_W  (OUT_W),
    .IDX_W  (IDX_W),
    .SEED_W (SEED_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inX        (inX),
    .outRecip   (outRecip),
    .outShift   (outShift),
    .outDivZero (outDivZero)
  );

  // R3: a nonzero result lies in [0.5, 1.0]
  assert_mant_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outDivZero) |-> (outRecip >= MANT_LO && outRecip <= MANT_HI));

  // R6: outputs hold while no result is being loaded
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ldOut |=> ($stable(outRecip) && $stable(outShift) && $stable(outDivZero)));

endmodule

// File: tb/test_recip_unit.sv
module test_recip_unit;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W       = 16;
  localparam int OUT_W      = 16;
  localparam int SHIFT_W    = $clog2(IN_W);
  localparam int LAT        = 3;
  localparam int N_RANDOM   = 4000;
  localparam int WATCHDOG   = 150000;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic [IN_W-1:0]    inX = '0;
  logic               outValid;
  logic [OUT_W-1:0]   outRecip;
  logic [SHIFT_W-1:0] outShift;
  logic               outDivZero;

  recip_unit #(.IN_W(IN_W), .OUT_W(OUT_W)) i_recip_unit (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inX        (inX),
    .outValid   (outValid),
    .outRecip   (outRecip),
    .outShift   (outShift),
    .outDivZero (outDivZero)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic            histV [LAT + 1];
  logic [IN_W-1:0] histX [LAT + 1];
  logic [OUT_W-1:0]   lastRecip = '0;
  logic [SHIFT_W-1:0] lastShift = '0;
  logic               lastZero  = 1'b0;

  function automatic int expShift(input logic [IN_W-1:0] x);
    int s = 0;
    logic [IN_W-1:0] t = x;
    if (x == '0) return 0;
    while (!t[IN_W-1]) begin
      t = t << 1;
      s++;
    end
    return s;
  endfunction

  function automatic longint expRecip(input logic [IN_W-1:0] x);
    longint xn;
    xn = longint'(x) << expShift(x);
    return (((longint'(1) << (OUT_W + IN_W - 1)) / xn) + 1) >> 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compareOut();
    int slot = (cyc + 1) % (LAT + 1);
    if (histV[slot]) begin
      logic [IN_W-1:0] x = histX[slot];
      check(outValid == 1'b1, "R5", "outValid for issued operand", outValid, 1);
      if (x == '0) begin
        check(outDivZero == 1'b1, "R4", "zero flag", outDivZero, 1);
        check(outRecip == '1, "R4", "saturated mantissa", outRecip, {OUT_W{1'b1}});
        check(outShift == '0, "R4", "zero shift", outShift, 0);
      end else begin
        longint e = expRecip(x);
        longint d = longint'(outRecip) - e;
        check(outDivZero == 1'b0, "R4", "flag clear for nonzero", outDivZero, 0);
        check(int'(outShift) == expShift(x), "R1", "shift count", outShift, expShift(x));
        check(d >= -1 && d <= 1, "R2", "mantissa accuracy", outRecip, e);
        check(outRecip >= (1 << (OUT_W - 2)) && outRecip <= (1 << (OUT_W - 1)),
              "R3", "mantissa range", outRecip, 1 << (OUT_W - 1));
        if ($countones(x) == 1)
          check(outRecip == (1 << (OUT_W - 1)), "R3", "power of two exact",
                outRecip, 1 << (OUT_W - 1));
      end
      lastRecip = outRecip;
      lastShift = outShift;
      lastZero  = outDivZero;
    end else begin
      check(outValid == 1'b0, "R5", "outValid idle", outValid, 0);
      check(outRecip == lastRecip, "R6", "held mantissa", outRecip, lastRecip);
      check(outShift == lastShift, "R6", "held shift", outShift, lastShift);
      check(outDivZero == lastZero, "R6", "held flag", outDivZero, lastZero);
    end
  endtask

  task automatic step(input bit v, input logic [IN_W-1:0] x);
    @(negedge clk);
    compareOut();
    inValid = v;
    inX     = x;
    histV[cyc % (LAT + 1)] = v;
    histX[cyc % (LAT + 1)] = x;
    cyc++;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog: actual %0d cycles expected completion", WATCHDOG);
    finishRun();
  end

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'd20240611);
    for (int i = 0; i <= LAT; i++) begin
      histV[i] = 1'b0;
      histX[i] = '0;
    end

    // R7: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R7", "reset outValid", outValid, 0);
    check(outRecip == '0, "R7", "reset outRecip", outRecip, 0);
    check(outShift == '0, "R7", "reset outShift", outShift, 0);
    check(outDivZero == 1'b0, "R7", "reset outDivZero", outDivZero, 0);
    rstN = 1'b1;

    // Directed corners, back to back (R1..R5)
    step(1'b1, 16'h0001);
    step(1'b1, 16'h0000);
    step(1'b1, 16'hFFFF);
    step(1'b1, 16'h8000);
    step(1'b1, 16'h8001);
    step(1'b1, 16'h00FF);
    step(1'b1, 16'h0180);
    step(1'b1, 16'h7FFF);
    step(1'b1, 16'h0000);
    step(1'b1, 16'h0003);
    // Idle gap: outputs hold (R6)
    for (int i = 0; i < 6; i++) step(1'b0, 16'hA5A5);

    // Every shift count on a power of two (R1, R3)
    for (int i = 0; i < IN_W; i++) step(1'b1, IN_W'(1) << i);

    // Random mix with gaps (R2, R4, R5, R6)
    for (int n = 0; n < N_RANDOM; n++) begin
      int unsigned sel = $urandom % 16;
      logic [IN_W-1:0] x;
      bit v = ($urandom % 4) != 0;
      if (sel == 0)      x = '0;
      else if (sel == 1) x = IN_W'(1) << ($urandom % IN_W);
      else if (sel == 2) x = IN_W'($urandom % 256);
      else               x = IN_W'($urandom);
      step(v, x);
    end

    for (int i = 0; i < LAT + 2; i++) step(1'b0, '0);
    finishRun();
  end

endmodule